// File: doc/BRIEF.md
# Linked-Descriptor Display Fetch Engine

This block feeds a display controller with memory data. It walks a linked list of descriptors that sit in memory. Each descriptor is four 32-bit words. It names the next descriptor, where the data lies, an identifier for the frame and a command word. The engine reads a descriptor, fetches the number of words the command gives in bursts of a selectable size, and then moves on to the next descriptor.

The command word sorts each transfer into one of two kinds. Palette loads go to a palette write port. Frame data goes to a valid/ready pixel-word stream through a small output FIFO. Software starts the engine by writing the address of the first descriptor. A chain can alternate between a palette descriptor and a frame descriptor, which suits indexed-colour modes. For true-colour operation a single frame descriptor can point back to itself.

A small output FIFO absorbs each burst. If the sink drains the FIFO while a frame is still being fetched, the engine reports an underrun. When underrun protection is on, it repeats the last word it sent and marks it as filler.

Top module: `frame_desc_dma`

## Requirements
- R1: A descriptor fetch is one memory read of 4 words at the descriptor address. The words are, in order: next-descriptor address, source address, frame ID and command. After the fetch, `cur_next`, `cur_src`, `cur_fid` and `cur_cmd` show those four words.
- R2: The transfer length in 32-bit words is command bits 23:0. Data words are read from the source address upward, with the address stepping by 4 bytes per word.
- R3: `burst_sel` sets the largest data burst: 0 gives 4 words, 1 gives 8 words, and 2 or 3 give 16 words. When the remaining count is smaller than the burst size, the last burst of a transfer is cut to that count. A request holds its address and length until it is granted.
- R4: When command bit 28 is 1 the transfer is a palette load. Word k of the load is written to the palette port at index k mod 128. Entries 2k and 2k+1 sit in the low and high halves of that word. A palette load sends nothing to the pixel stream. When bit 28 is 0, the data words appear on the pixel stream in memory order.
- R5: When a frame descriptor completes, `eof` pulses for one cycle and `cur_fid` shows that descriptor's ID. Palette descriptors give no pulse. The engine then fetches the descriptor named by the next pointer, so chains that alternate and chains that point to themselves both repeat without end.
- R6: A descriptor with length 0 makes no data request. It completes straight after its fetch.
- R7: A frame-data burst is requested only when the FIFO has room for the whole burst. While the stream is stalled, a valid word that is not filler stays valid and does not change.
- R8: `underrun` is high in a cycle where `pix_ready` is high, the FIFO is empty and a frame transfer is still in progress. If `ufl_protect` is 1, the stream then presents the last word it sent, with `pix_valid` and `pix_fill` both high. If `ufl_protect` is 0, `pix_valid` stays low and `pix_fill` is never set.
- R9: A write on `da_we` while the engine is idle starts a fetch at `da_wdata`. A write while the engine is busy replaces the next pointer used when the current descriptor ends.
- R10: After reset, `mem_req`, `pix_valid`, `pal_we`, `eof` and `underrun` are low and all `cur_*` outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| burst_sel | input | 2 | Burst size select (0:4, 1:8, 2/3:16 words) |
| ufl_protect | input | 1 | Underrun protection enable |
| da_we | input | 1 | Descriptor-address write strobe |
| da_wdata | input | 32 | Descriptor byte address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Request byte address |
| mem_len | output | 5 | Request length in words |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Response word valid |
| mem_rdata | input | 32 | Response word |
| pix_valid | output | 1 | Pixel word valid |
| pix_ready | input | 1 | Sink ready |
| pix_data | output | 32 | Pixel word |
| pix_fill | output | 1 | Word is a repeated filler |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette word index |
| pal_data | output | 32 | Two 16-bit palette entries |
| eof | output | 1 | Frame descriptor done pulse |
| underrun | output | 1 | Sink found no buffered word during a frame |
| cur_next | output | 32 | Current descriptor: next pointer |
| cur_src | output | 32 | Current descriptor: source address |
| cur_fid | output | 32 | Current descriptor: frame ID |
| cur_cmd | output | 32 | Current descriptor: command |

## Verification
The checker watches these rules on every cycle:
- A pending memory request holds steady, and no request is larger than the selected burst.
- A stalled pixel word that is not filler stays fixed.
- Filler words appear only with protection on, and without protection an underrun cycle shows no valid word.
- `eof` lasts a single cycle, and palette writes come only from memory responses.

The bench scenarios cover what the checker cannot see from one cycle: the order of addresses and burst lengths across a whole chain, how a transfer is split, which data ends up on the stream and which on the palette port, wrap of the palette index, frame IDs at each end of frame, and redirection by a write in mid-chain.

// File: rtl/frame_desc_dma.sv
module frame_desc_dma #(
  parameter int LEN_W      = 24,
  parameter int PAL_BIT    = 28,
  parameter int FIFO_DEPTH = 32,
  parameter int PAL_WORDS  = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  burst_sel,
  input  logic        ufl_protect,
  input  logic        da_we,
  input  logic [31:0] da_wdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  output logic [4:0]  mem_len,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        pix_valid,
  input  logic        pix_ready,
  output logic [31:0] pix_data,
  output logic        pix_fill,
  output logic        pal_we,
  output logic [6:0]  pal_idx,
  output logic [31:0] pal_data,
  output logic        eof,
  output logic        underrun,
  output logic [31:0] cur_next,
  output logic [31:0] cur_src,
  output logic [31:0] cur_fid,
  output logic [31:0] cur_cmd
);
  localparam int FAW = $clog2(FIFO_DEPTH);
  localparam int CW  = FAW + 1;
  localparam int PIW = $clog2(PAL_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DRCV, S_XREQ, S_XRCV, S_DONE} st_t;
  st_t state;

  logic [31:0]      desc_ptr, nda_q, src_q, fid_q, cmd_q, addr_q, sw_ptr, last_q;
  logic             sw_pend;
  logic [1:0]       wsel;
  logic [LEN_W-1:0] rem_q;
  logic [4:0]       brem_q;
  logic [PIW-1:0]   off_q;
  logic [31:0]      fifo [FIFO_DEPTH];
  logic [FAW-1:0]   wp, rp;
  logic [CW-1:0]    cnt;
  logic [4:0]       blen;

  always_comb begin
    case (burst_sel)
      2'd0:    blen = 5'd4;
      2'd1:    blen = 5'd8;
      default: blen = 5'd16;
    endcase
  end

  wire             is_pal     = cmd_q[PAL_BIT];
  wire [4:0]       bsz        = (rem_q < LEN_W'(blen)) ? rem_q[4:0] : blen;
  wire [CW-1:0]    free       = CW'(FIFO_DEPTH) - cnt;
  wire             room       = is_pal || (free >= CW'(bsz));
  wire             empty      = (cnt == '0);
  wire             frame_busy = !is_pal && (state == S_XREQ || state == S_XRCV);
  wire             rx         = mem_rvalid && (state == S_XRCV);
  wire             push       = rx && !is_pal;
  wire             pop        = pix_ready && !empty;
  wire             gnt        = mem_req && mem_gnt;
  wire [31:0]      next_ptr   = da_we ? da_wdata : (sw_pend ? sw_ptr : nda_q);
  wire [LEN_W-1:0] cmd_len    = mem_rdata[LEN_W-1:0];

  assign mem_req   = (state == S_DREQ) || (state == S_XREQ && room);
  assign mem_addr  = (state == S_DREQ) ? desc_ptr : addr_q;
  assign mem_len   = (state == S_DREQ) ? 5'd4 : bsz;
  assign pal_we    = rx && is_pal;
  assign pal_idx   = 7'(off_q);
  assign pal_data  = mem_rdata;
  assign pix_fill  = empty && ufl_protect && frame_busy;
  assign pix_valid = !empty || pix_fill;
  assign pix_data  = empty ? last_q : fifo[rp];
  assign underrun  = pix_ready && empty && frame_busy;
  assign eof       = (state == S_DONE) && !is_pal;
  assign cur_next  = nda_q;
  assign cur_src   = src_q;
  assign cur_fid   = fid_q;
  assign cur_cmd   = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      desc_ptr <= '0;
      nda_q    <= '0;
      src_q    <= '0;
      fid_q    <= '0;
      cmd_q    <= '0;
      addr_q   <= '0;
      sw_ptr   <= '0;
      sw_pend  <= 1'b0;
      wsel     <= '0;
      rem_q    <= '0;
      brem_q   <= '0;
      off_q    <= '0;
    end else begin
      if (da_we && state != S_IDLE && state != S_DONE) begin
        sw_pend <= 1'b1;
        sw_ptr  <= da_wdata;
      end
      case (state)
        S_IDLE: if (da_we) begin
          desc_ptr <= da_wdata;
          state    <= S_DREQ;
        end
        S_DREQ: if (gnt) begin
          wsel  <= '0;
          state <= S_DRCV;
        end
        S_DRCV: if (mem_rvalid) begin
          wsel <= wsel + 2'd1;
          case (wsel)
            2'd0: nda_q <= mem_rdata;
            2'd1: src_q <= mem_rdata;
            2'd2: fid_q <= mem_rdata;
            default: begin
              cmd_q  <= mem_rdata;
              rem_q  <= cmd_len;
              addr_q <= src_q;
              off_q  <= '0;
              state  <= (cmd_len == '0) ? S_DONE : S_XREQ;
            end
          endcase
        end
        S_XREQ: if (gnt) begin
          brem_q <= bsz;
          state  <= S_XRCV;
        end
        S_XRCV: if (mem_rvalid) begin
          addr_q <= addr_q + 32'd4;
          rem_q  <= rem_q - LEN_W'(1);
          off_q  <= off_q + PIW'(1);
          brem_q <= brem_q - 5'd1;
          if (brem_q == 5'd1)
            state <= (rem_q == LEN_W'(1)) ? S_DONE : S_XREQ;
        end
        S_DONE: begin
          desc_ptr <= next_ptr;
          sw_pend  <= 1'b0;
          state    <= S_DREQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      last_q <= '0;
    end else begin
      if (push) wp <= wp + FAW'(1);
      if (pop) begin
        rp     <= rp + FAW'(1);
        last_q <= fifo[rp];
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= mem_rdata;
  end
endmodule

// File: rtl/frame_desc_dma_chk.sv
module frame_desc_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  burst_sel,
  input logic        ufl_protect,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic [4:0]  mem_len,
  input logic        mem_gnt,
  input logic        mem_rvalid,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [31:0] pix_data,
  input logic        pix_fill,
  input logic        pal_we,
  input logic        eof,
  input logic        underrun
);
  logic [4:0] cap;
  assign cap = (burst_sel == 2'd0) ? 5'd4 : (burst_sel == 2'd1) ? 5'd8 : 5'd16;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len)); // R3
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != 5'd0) && (mem_len <= cap)); // R3
  AST_PAL_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> mem_rvalid); // R4
  AST_EOF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof); // R5
  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready && !pix_fill |=> pix_valid && !pix_fill && $stable(pix_data)); // R7
  AST_FILL_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fill |-> ufl_protect && pix_valid); // R8
  AST_UNPROT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !ufl_protect |-> !pix_valid); // R8
  AST_UNDERRUN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> pix_ready); // R8
endmodule

bind frame_desc_dma frame_desc_dma_chk chk_i (
  .clk(clk), .rst_n(rst_n), .burst_sel(burst_sel), .ufl_protect(ufl_protect),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
  .mem_rvalid(mem_rvalid), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_data(pix_data), .pix_fill(pix_fill), .pal_we(pal_we), .eof(eof),
  .underrun(underrun)
);

// File: tb/frame_desc_dma_tb_top.sv
module frame_desc_dma_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  burst_sel = 2'd0;
  logic        ufl_protect = 1'b0;
  logic        da_we = 1'b0;
  logic [31:0] da_wdata = '0;
  logic        mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [4:0]  mem_len;
  logic        pix_valid, pix_ready = 1'b0, pix_fill;
  logic [31:0] pix_data;
  logic        pal_we, eof, underrun;
  logic [6:0]  pal_idx;
  logic [31:0] pal_data, cur_next, cur_src, cur_fid, cur_cmd;

  frame_desc_dma dut_i (
    .clk(clk), .rst_n(rst_n), .burst_sel(burst_sel), .ufl_protect(ufl_protect),
    .da_we(da_we), .da_wdata(da_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data), .pix_fill(pix_fill),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_data(pal_data), .eof(eof), .underrun(underrun),
    .cur_next(cur_next), .cur_src(cur_src), .cur_fid(cur_fid), .cur_cmd(cur_cmd)
  );

  int total = 0, bad = 0;
  int gnt_pct, dat_pct, rdy_pct;
  int eof_cnt, un_cnt, fill_cnt, pal_cnt;
  int pend;
  logic [31:0] paddr, last_real;
  logic        do_wr = 1'b0;
  logic [31:0] wr_val = '0;
  logic [31:0] dsc [0:255];
  logic [31:0] q_pix[$], q_pald[$], q_fid[$], q_ra[$];
  int          q_pali[$], q_rl[$];

  function automatic logic [31:0] dword(logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'h5BD1_E995;
  endfunction

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return (a < 32'h400) ? dsc[a[9:2]] : dword(a);
  endfunction

  function automatic int cap_of(logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : 16;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] src,
                          input logic [31:0] fid, input logic [31:0] cmd);
    dsc[a[9:2]]       = nx;
    dsc[a[9:2] + 8'd1] = src;
    dsc[a[9:2] + 8'd2] = fid;
    dsc[a[9:2] + 8'd3] = cmd;
  endtask

  // expected model of one descriptor: requests, data routing, end-of-frame ID
  task automatic walk(inout logic [31:0] a);
    logic [31:0] nx, src, fid, cmd;
    int len, cap;
    nx = dsc[a[9:2]]; src = dsc[a[9:2] + 8'd1];
    fid = dsc[a[9:2] + 8'd2]; cmd = dsc[a[9:2] + 8'd3];
    len = int'(cmd[23:0]);
    cap = cap_of(burst_sel);
    q_ra.push_back(a); q_rl.push_back(4);
    for (int i = 0; i < len; i += cap) begin
      q_ra.push_back(src + 32'(4 * i));
      q_rl.push_back((len - i < cap) ? len - i : cap);
    end
    for (int i = 0; i < len; i++) begin
      if (cmd[28]) begin
        q_pali.push_back(i % 128);
        q_pald.push_back(dword(src + 32'(4 * i)));
      end else q_pix.push_back(dword(src + 32'(4 * i)));
    end
    if (!cmd[28]) q_fid.push_back(fid);
    a = nx;
  endtask

  task automatic plan_chain(input logic [31:0] start, input int steps);
    logic [31:0] a;
    a = start;
    for (int i = 0; i < steps; i++) walk(a);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    q_pix.delete(); q_pald.delete(); q_fid.delete(); q_ra.delete();
    q_pali.delete(); q_rl.delete();
    pend = 0; eof_cnt = 0; un_cnt = 0; fill_cnt = 0; pal_cnt = 0; last_real = '0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; pix_ready = 1'b0; da_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cycle();
    @(negedge clk);
    da_we = do_wr; da_wdata = wr_val; do_wr = 1'b0;
    pix_ready = ($urandom % 100) < rdy_pct;
    mem_rvalid = 1'b0;
    mem_gnt = 1'b0;
    if (pend > 0) begin
      if (($urandom % 100) < dat_pct) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem_rd(paddr);
      end
    end else mem_gnt = ($urandom % 100) < gnt_pct;
    #1;
    if (mem_rvalid) begin paddr += 32'd4; pend--; end
    if (mem_req && mem_gnt) begin
      if (q_ra.size() == 0) check(0, "R1 unexpected request", mem_addr, '0);
      else begin
        logic [31:0] ea; int el;
        ea = q_ra.pop_front(); el = q_rl.pop_front();
        check(mem_addr == ea, "R2 request address", mem_addr, ea);
        check(int'(mem_len) == el, "R3 burst length", 32'(mem_len), 32'(el));
      end
      pend = int'(mem_len); paddr = mem_addr;
    end
    if (pix_valid && pix_ready) begin
      if (pix_fill) begin
        fill_cnt++;
        check(pix_data == last_real, "R8 filler repeats last word", pix_data, last_real);
      end else if (q_pix.size() == 0) check(0, "R4 unexpected pixel", pix_data, '0);
      else begin
        logic [31:0] e;
        e = q_pix.pop_front();
        check(pix_data == e, "R4 pixel word order", pix_data, e);
        last_real = pix_data;
      end
    end
    if (pal_we) begin
      pal_cnt++;
      if (q_pald.size() == 0) check(0, "R4 unexpected palette write", pal_data, '0);
      else begin
        logic [31:0] e; int ei;
        e = q_pald.pop_front(); ei = q_pali.pop_front();
        check(pal_data == e, "R4 palette data", pal_data, e);
        check(int'(pal_idx) == ei, "R4 palette index", 32'(pal_idx), 32'(ei));
      end
    end
    if (eof) begin
      eof_cnt++;
      if (q_fid.size() == 0) check(0, "R5 unexpected eof", cur_fid, '0);
      else begin
        logic [31:0] e;
        e = q_fid.pop_front();
        check(cur_fid == e, "R5 frame id at eof", cur_fid, e);
      end
    end
    if (underrun) un_cnt++;
  endtask

  task automatic run_until(input int frames, input string tag);
    int n = 0;
    while (eof_cnt < frames && n < 12000) begin cycle(); n++; end
    check(eof_cnt >= frames, tag, 32'(eof_cnt), 32'(frames));
  endtask

  task automatic start(input logic [31:0] a);
    do_wr = 1'b1; wr_val = a;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) dsc[i] = '0;
    gnt_pct = 100; dat_pct = 100; rdy_pct = 100;
    do_reset();
    @(negedge clk); #1;
    check(!mem_req && !pix_valid && !pal_we && !eof && !underrun, "R10 outputs idle after reset",
          {mem_req, pix_valid, pal_we, eof, underrun}, '0);
    check((cur_next | cur_src | cur_fid | cur_cmd) == '0, "R10 descriptor view cleared",
          cur_next | cur_src | cur_fid | cur_cmd, '0);

    // R1 R2 R3 R5: self-looping true-colour descriptor, 10 words in 4-word bursts
    put_desc(32'h00, 32'h00, 32'h1000, 32'd7, 32'd10);
    burst_sel = 2'd0; plan_chain(32'h00, 8); start(32'h00);
    run_until(3, "R5 self loop frames");
    check(cur_next == 32'h00 && cur_src == 32'h1000, "R1 descriptor view", cur_src, 32'h1000);
    check(cur_cmd == 32'd10, "R1 command view", cur_cmd, 32'd10);

    // R4 R5: palette / frame alternation, 8-word bursts
    do_reset();
    put_desc(32'h40, 32'h50, 32'h2000, 32'd1, (32'd1 << 28) | 32'd128);
    put_desc(32'h50, 32'h40, 32'h3000, 32'd9, 32'd24);
    burst_sel = 2'd1; rdy_pct = 60; plan_chain(32'h40, 10); start(32'h40);
    run_until(3, "R5 alternating chain frames");
    check(pal_cnt >= 384, "R4 palette words routed", 32'(pal_cnt), 32'd384);

    // R3: 16-word bursts with short tails, both encodings of the large size
    for (int s = 2; s < 4; s++) begin
      do_reset();
      put_desc(32'h80, 32'h80, 32'h4000, 32'd5, (s == 2) ? 32'd37 : 32'd20);
      burst_sel = 2'(s); rdy_pct = 80; plan_chain(32'h80, 6); start(32'h80);
      run_until(2, "R3 16-word burst frames");
    end

    // R6: zero-length descriptor in a ring
    do_reset();
    put_desc(32'h60, 32'h70, 32'h1800, 32'd3, 32'd0);
    put_desc(32'h70, 32'h60, 32'h1900, 32'd4, 32'd5);
    burst_sel = 2'd0; rdy_pct = 100; plan_chain(32'h60, 10); start(32'h60);
    run_until(4, "R6 zero-length frames");

    // R8: slow memory, fast sink, protection on then off
    for (int p = 1; p >= 0; p--) begin
      do_reset();
      put_desc(32'h00, 32'h00, 32'h5000, 32'd11, 32'd40);
      burst_sel = 2'd0; ufl_protect = 1'(p); gnt_pct = 30; dat_pct = 20; rdy_pct = 100;
      plan_chain(32'h00, 6); start(32'h00);
      run_until(2, "R8 underrun frames");
      check(un_cnt > 0, "R8 underrun seen", 32'(un_cnt), 32'd1);
      if (p == 1) check(fill_cnt > 0, "R8 filler with protection", 32'(fill_cnt), 32'd1);
      else check(fill_cnt == 0, "R8 no filler without protection", 32'(fill_cnt), 32'd0);
    end
    ufl_protect = 1'b0; gnt_pct = 100; dat_pct = 100;

    // R9: write while busy redirects the next fetch
    do_reset();
    put_desc(32'h80, 32'h80, 32'h6000, 32'd1, 32'd6);
    put_desc(32'h90, 32'h90, 32'h7000, 32'd2, 32'd3);
    burst_sel = 2'd0; rdy_pct = 70;
    begin
      logic [31:0] a;
      a = 32'h80; walk(a); a = 32'h80; walk(a);
      a = 32'h90; for (int i = 0; i < 6; i++) walk(a);
    end
    start(32'h80);
    run_until(1, "R9 first frame");
    start(32'h90);
    run_until(4, "R9 redirected frames");

    // R2 R3 R4 R6 R7: random rings
    for (int it = 0; it < 6; it++) begin
      do_reset();
      for (int k = 0; k < 4; k++) begin
        logic [31:0] cmd;
        if (k > 0 && ($urandom % 4) == 0) cmd = (32'd1 << 28) | 32'(1 + $urandom % 140);
        else cmd = 32'((k == 0) ? 1 + $urandom % 40 : $urandom % 41);
        put_desc(32'h100 + 32'(16 * k), 32'h100 + 32'(16 * ((k + 1) % 4)),
                 32'h2000 + 32'(k * 32'h1000) + 32'(it * 32'h10000), $urandom, cmd);
      end
      burst_sel = 2'($urandom % 4); ufl_protect = 1'($urandom % 2);
      gnt_pct = 40 + $urandom % 61; dat_pct = 40 + $urandom % 61; rdy_pct = 30 + $urandom % 71;
      plan_chain(32'h100, 24); start(32'h100);
      run_until(5, "R7 random ring frames");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule